// File: doc/BRIEF.md
# Transfer Count and Address Tracker

This block follows the progress of one bus data transfer. It keeps a byte count that runs down and a host byte address that runs up. Both move together, by one, each time the bus side reports that a byte has been committed. A byte that has only been requested never moves them. The address therefore always names the next byte after the last one that was really transferred. Write-ahead prefetch has no effect on it.

Software reaches the block through a small byte-wide register port. It loads the start count and the start address, can zero the count with a control strobe, and reads everything back. Two latched events are kept: the count arriving at zero, and the count rolling under from zero. Each has its own interrupt enable. Each is cleared by writing a one to its bit in the status register.

Top module: `xfer_tracker`

## Requirements
- R1: After reset the count, the address, both status bits, both enable bits and `irq_o` are all zero.
- R2: The 24-bit count is loaded and read as bytes at register offsets 0x0 (bits 7:0), 0x1 (bits 15:8) and 0x2 (bits 23:16). The 32-bit address uses offsets 0x4 (bits 7:0) through 0x7 (bits 31:24). A write replaces only the addressed byte.
- R3: When `byte_done_i` is high at a clock edge and no load takes place in that cycle, the count drops by one and the address rises by one at that edge. Without `byte_done_i`, neither of them changes.
- R4: A load takes precedence over a completion in the same cycle. A load is a write to any count byte, any address byte, or the control register with bit 0 set. The completion is then discarded: the count and address take only the written value.
- R5: Writing the control register (offset 0x8) with bit 0 set zeroes the count and leaves the address unchanged. The control register reads as 0x00.
- R6: Status bit 0 (done) is set by an accepted completion that takes the count from 1 to 0. It is not set by the control strobe or by a load of zero. It is not set again while the count simply stays at zero.
- R7: Status bit 1 (wrap) is set by an accepted completion at count 0, which leaves the count at 0xFFFFFF.
- R8: The status register is at offset 0x9. Writing 1 to a bit clears it, and writing 0 leaves it alone. If a bit is set and cleared in the same cycle, the set wins.
- R9: The enable register is at offset 0xA, with bit 0 enabling done and bit 1 enabling wrap. `irq_o` is high exactly when some status bit and its enable are both set. It is visible in the cycle after the event.
- R10: Reads of offsets 0x3 and 0xB to 0xF return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset for read and write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| byte_done_i | input | 1 | One byte committed on the bus this cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
Runs of bare completions from small loaded counts show whether the done event comes only on the step from one to zero. Further steps at zero show the wrap event and that done does not fire again. Completions that collide with count, address and control writes separate the load-wins rule from an implementation that applies both. Mixed random traffic also hits the unmapped offsets, status clears that collide with new events, and changes to the enables, and it is compared against a bench model after each step.

// File: rtl/xfer_tracker_pkg.sv
package xfer_tracker_pkg;
  localparam int unsigned REG_AW = 4;
  localparam logic [REG_AW-1:0] OFS_CNT = 4'h0;
  localparam logic [REG_AW-1:0] OFS_ADR = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CTL = 4'h8;
  localparam logic [REG_AW-1:0] OFS_STS = 4'h9;
  localparam logic [REG_AW-1:0] OFS_IEN = 4'hA;
  localparam int unsigned EVT_N = 2;
  typedef enum int unsigned {EVT_DONE = 0, EVT_WRAP = 1} evt_e;
endpackage

// File: rtl/xfer_counter.sv
module xfer_counter #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned ADR_W = 32,
  localparam int unsigned CNT_B = CNT_W / 8,
  localparam int unsigned ADR_B = ADR_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_B-1:0] cnt_we_i,
  input  logic [ADR_B-1:0] adr_we_i,
  input  logic             cnt_clr_i,
  input  logic [7:0]       wdata_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [ADR_W-1:0] adr_o,
  output logic             zero_evt_o,
  output logic             wrap_evt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ADR_W-1:0] adr_q, adr_d;
  logic load, go;

  assign load = (|cnt_we_i) | (|adr_we_i) | cnt_clr_i;
  assign go   = step_i & ~load;  // software load wins

  always_comb begin
    cnt_d = cnt_q;
    adr_d = adr_q;
    if (cnt_clr_i) cnt_d = '0;
    for (int i = 0; i < CNT_B; i++)
      if (cnt_we_i[i]) cnt_d[i*8 +: 8] = wdata_i;
    for (int i = 0; i < ADR_B; i++)
      if (adr_we_i[i]) adr_d[i*8 +: 8] = wdata_i;
    if (go) begin
      cnt_d = cnt_q - CNT_W'(1);
      adr_d = adr_q + ADR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      adr_q <= adr_d;
    end
  end

  assign zero_evt_o = go && (cnt_q == CNT_W'(1));
  assign wrap_evt_o = go && (cnt_q == '0);
  assign cnt_o = cnt_q;
  assign adr_o = adr_q;

  a_r3_step_moves_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)) && (adr_q == $past(adr_q) + ADR_W'(1)));
  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load) |=> $stable(cnt_q) && $stable(adr_q));
  a_r4_adr_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (|adr_we_i) && !(|cnt_we_i) && !cnt_clr_i) |=> $stable(cnt_q));
  a_r5_clr_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_clr_i && !(|cnt_we_i)) |=> (cnt_q == '0) && $stable(adr_q));
endmodule

// File: rtl/xfer_irq.sv
module xfer_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] sts_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_i) | set_i;  // set beats clear
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = |(sts_q & en_q);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)));
  a_r8_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(sts_q));
  a_r9_no_irq_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker
  import xfer_tracker_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned ADR_W = 32,
  localparam int unsigned CNT_B = CNT_W / 8,
  localparam int unsigned ADR_B = ADR_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              byte_done_i,
  output logic              irq_o
);
  logic [CNT_B-1:0] cnt_we;
  logic [ADR_B-1:0] adr_we;
  logic             cnt_clr, sts_we, ien_we;
  logic [CNT_W-1:0] cnt;
  logic [ADR_W-1:0] adr;
  logic             zero_evt, wrap_evt;
  logic [EVT_N-1:0] evt_set, evt_clr, sts, ien;

  for (genvar g = 0; g < CNT_B; g++) begin : g_cnt_dec
    assign cnt_we[g] = reg_we_i && (reg_addr_i == OFS_CNT + REG_AW'(g));
  end
  for (genvar g = 0; g < ADR_B; g++) begin : g_adr_dec
    assign adr_we[g] = reg_we_i && (reg_addr_i == OFS_ADR + REG_AW'(g));
  end
  assign cnt_clr = reg_we_i && (reg_addr_i == OFS_CTL) && reg_wdata_i[0];
  assign sts_we  = reg_we_i && (reg_addr_i == OFS_STS);
  assign ien_we  = reg_we_i && (reg_addr_i == OFS_IEN);

  xfer_counter #(.CNT_W(CNT_W), .ADR_W(ADR_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_we_i   (cnt_we),
    .adr_we_i   (adr_we),
    .cnt_clr_i  (cnt_clr),
    .wdata_i    (reg_wdata_i),
    .step_i     (byte_done_i),
    .cnt_o      (cnt),
    .adr_o      (adr),
    .zero_evt_o (zero_evt),
    .wrap_evt_o (wrap_evt)
  );

  always_comb begin
    evt_set = '0;
    evt_set[EVT_DONE] = zero_evt;
    evt_set[EVT_WRAP] = wrap_evt;
  end
  assign evt_clr = sts_we ? reg_wdata_i[EVT_N-1:0] : '0;

  xfer_irq #(.N(EVT_N)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (evt_set),
    .clr_i      (evt_clr),
    .en_we_i    (ien_we),
    .en_wdata_i (reg_wdata_i[EVT_N-1:0]),
    .sts_o      (sts),
    .en_o       (ien),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < CNT_B; i++)
      if (reg_addr_i == OFS_CNT + REG_AW'(i)) reg_rdata_o = cnt[i*8 +: 8];
    for (int i = 0; i < ADR_B; i++)
      if (reg_addr_i == OFS_ADR + REG_AW'(i)) reg_rdata_o = adr[i*8 +: 8];
    if (reg_addr_i == OFS_STS) reg_rdata_o = 8'(sts);
    if (reg_addr_i == OFS_IEN) reg_rdata_o = 8'(ien);
  end

  a_r6_done_only_from_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts[EVT_DONE]) |-> ($past(cnt) == CNT_W'(1)) && (cnt == '0));
  a_r7_wrap_to_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts[EVT_WRAP]) |-> ($past(cnt) == '0) && (cnt == '1));
endmodule

// File: tb/test_xfer_tracker.sv
`timescale 1ns/1ps
module test_xfer_tracker;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wd = 8'h00;
  logic       bdone = 1'b0;
  logic [7:0] rd;
  logic       irq;

  int checks = 0;
  int errs = 0;

  logic [23:0] m_cnt;
  logic [31:0] m_adr;
  logic [1:0]  m_sts, m_en;

  always #4 clk = ~clk;

  xfer_tracker i_xfer_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .byte_done_i(bdone), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_step(input logic w, input logic [3:0] a,
                                     input logic [7:0] d, input logic bd);
    logic load, go;
    logic [1:0] set, clr;
    load = w && (a <= 4'h2 || (a >= 4'h4 && a <= 4'h7) || (a == 4'h8 && d[0]));
    go   = bd && !load;
    set  = {go && m_cnt == 24'h0, go && m_cnt == 24'h1};
    clr  = (w && a == 4'h9) ? d[1:0] : 2'b00;
    if (w) begin
      if (a <= 4'h2) m_cnt[a*8 +: 8] = d;
      if (a >= 4'h4 && a <= 4'h7) m_adr[(a-4)*8 +: 8] = d;
      if (a == 4'h8 && d[0]) m_cnt = 24'h0;
      if (a == 4'hA) m_en = d[1:0];
    end
    if (go) begin
      m_cnt = m_cnt - 24'h1;
      m_adr = m_adr + 32'h1;
    end
    m_sts = (m_sts & ~clr) | set;
  endfunction

  task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d, input logic bd);
    @(negedge clk);
    we = w; addr = a; wd = d; bdone = bd;
    @(posedge clk);
    model_step(w, a, d, bd);
    #1;
    we = 1'b0; bdone = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd;
  endtask

  task automatic check_all(input string req);
    logic [7:0] b;
    logic [23:0] c;
    logic [31:0] ad;
    for (int i = 0; i < 3; i++) begin rd_reg(4'(i), b); c[i*8 +: 8] = b; end
    for (int i = 0; i < 4; i++) begin rd_reg(4'(4 + i), b); ad[i*8 +: 8] = b; end
    chk({req, " count"}, 32'(c), 32'(m_cnt));
    chk({req, " address"}, ad, m_adr);
    rd_reg(4'h9, b); chk({req, " status"}, 32'(b), 32'(m_sts));
    rd_reg(4'hA, b); chk({req, " enable"}, 32'(b), 32'(m_en));
    chk({req, " irq"}, 32'(irq), 32'(|(m_sts & m_en)));
  endtask

  task automatic load_cnt(input logic [23:0] v);
    cyc(1'b1, 4'h0, v[7:0], 1'b0);
    cyc(1'b1, 4'h1, v[15:8], 1'b0);
    cyc(1'b1, 4'h2, v[23:16], 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20417));
    m_cnt = '0; m_adr = '0; m_sts = '0; m_en = '0;
    #20; rst_ni = 1'b1;
    #3;
    check_all("R1 reset");

    // R2 byte loads
    load_cnt(24'h000002);
    for (int i = 0; i < 4; i++) cyc(1'b1, 4'(4 + i), 8'(8'hF0 + i), 1'b0);
    check_all("R2 load");
    // R9 enable done only
    cyc(1'b1, 4'hA, 8'h01, 1'b0);
    // R3 idle keeps, then two completions; R6 done at 1->0
    cyc(1'b0, 4'h0, 8'h00, 1'b0);
    cyc(1'b0, 4'h0, 8'h00, 1'b1);
    check_all("R3 first step");
    cyc(1'b0, 4'h0, 8'h00, 1'b1);
    check_all("R6 done set, R9 irq");
    // R8 clear done; write 0 to wrap no effect
    cyc(1'b1, 4'h9, 8'h01, 1'b0);
    check_all("R8 clear done");
    // R6 clear count again while zero: no new done
    cyc(1'b1, 4'h8, 8'h01, 1'b0);
    check_all("R6 no refire");
    // R7 wrap from zero, also check R9 wrap masked
    cyc(1'b0, 4'h0, 8'h00, 1'b1);
    check_all("R7 wrap masked");
    cyc(1'b1, 4'hA, 8'h02, 1'b0);
    check_all("R9 wrap enabled");
    // R4 completion colliding with loads
    cyc(1'b1, 4'h1, 8'h12, 1'b1);
    check_all("R4 count load wins");
    cyc(1'b1, 4'h6, 8'h55, 1'b1);
    check_all("R4 address load wins");
    cyc(1'b1, 4'h8, 8'h01, 1'b1);
    check_all("R4 R5 clear strobe wins");
    rd_reg(4'h8, v); chk("R5 control reads zero", 32'(v), 32'h0);
    // R8 set and clear same cycle: set wins
    load_cnt(24'h000001);
    cyc(1'b1, 4'h9, 8'h03, 1'b0);
    check_all("R8 cleared both");
    load_cnt(24'h000001);
    @(negedge clk); we = 1'b1; addr = 4'h9; wd = 8'h01; bdone = 1'b1;
    @(posedge clk); #1; we = 1'b0; bdone = 1'b0;
    m_sts = m_sts | 2'b01; m_cnt = 24'h0; m_adr = m_adr + 32'h1;
    check_all("R8 set wins over clear");
    // R10 unmapped
    cyc(1'b1, 4'hB, 8'hFF, 1'b0);
    cyc(1'b1, 4'h3, 8'hFF, 1'b0);
    check_all("R10 unmapped write");
    rd_reg(4'h3, v); chk("R10 read 0x3", 32'(v), 32'h0);
    rd_reg(4'hF, v); chk("R10 read 0xF", 32'(v), 32'h0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 9) cyc(1'b0, 4'h0, 8'h00, 1'b1);
      else if (r < 11) cyc(1'b1, 4'($urandom % 3), 8'($urandom % 4), r[0]);
      else cyc(1'b1, 4'($urandom % 16), 8'($urandom), 1'($urandom));
      if (n % 7 == 0) check_all("R3 R6 R7 R8 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule